// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the device-side digital logic that a delta-sigma converter uses to talk to a host over a 3- or 4-wire synchronous serial link. The block moves through three states. It is converting while the modulator works. It sleeps once a result is ready and the host is not selecting it. It enters the output state when the host pulls chip select low. Outside the output state, the data pin acts as a busy/ready flag.

In the output state the host clocks out a 24-bit result frame, MSB first. At the same time it clocks in configuration bits that apply to the next conversion. Reading the whole frame starts a new conversion. Raising chip select partway through the frame abandons the read and also restarts conversion. The modulator is a stub that delivers a done pulse with an 18-bit signed value. Only an externally supplied serial clock is handled.

The serial pins are sampled by a system clock that runs at least four times faster than the serial clock. Edges of the serial clock are detected in that clock domain.

Top module: `adc_serial_port`

## Requirements
- R1: `sdo_oe` is low whenever the synchronized chip select is high, and high whenever it is low.
- R2: While a conversion is in progress and chip select is low, `sdo` is 1.
- R3: A done pulse during conversion makes the result ready and `sdo` reads 0 when chip select is low. A done pulse outside conversion is ignored and the ready result is kept.
- R4: The frame is 24 bits, MSB first. In order: a 0 ready bit, a 0 filler bit, the sign bit, the low 17 bits of the two's-complement value (MSB first), then four 0 bits.
- R5: The sign bit is 1 when the value is zero or positive and 0 when it is negative.
- R6: `sdo` moves to the next frame bit only after a falling SCK edge. A rising edge leaves it unchanged. SDI is sampled on rising edges.
- R7: The 24th rising SCK edge ends the frame. It produces a one-cycle `conv_start` pulse and returns the block to converting.
- R8: Raising chip select after 1 to 23 rising SCK edges aborts the read. It produces one `conv_start` pulse and leaves `cfg_word` unchanged.
- R9: Raising chip select before any rising SCK edge returns the block to sleep with the result intact and with no `conv_start`. A later read delivers the full frame again.
- R10: The SDI bits on the first 16 rising edges of a frame form `cfg_word`, first bit as MSB. `cfg_word` updates only when a frame completes.
- R11: After reset the block is converting, `cfg_word` is 0 and `conv_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data in |
| conv_done | input | 1 | One-cycle pulse from the modulator stub |
| conv_value | input | 18 | Signed conversion result |
| sdo | output | 1 | Serial data / busy-ready flag |
| sdo_oe | output | 1 | Output enable for the `sdo` driver |
| cfg_word | output | 16 | Configuration for the next conversion |
| conv_start | output | 1 | Pulse requesting a new conversion |

## Verification
Some rules are checked on every cycle:
- a done pulse always leads to sleep;
- an abort or a completed frame always yields a start pulse and a return to converting;
- the data bit never moves without a falling SCK edge;
- `cfg_word` cannot change outside the output state.

Other behaviour can only be shown by the bench scenarios. These include the exact frame contents for each value, the sign at the zero and extreme values, and the number of start pulses. They also include the re-read after an early deselect and whether a random abort point preserves the earlier configuration.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RES_BITS  = 17,
  parameter int TAIL_BITS = 4,
  parameter int CFG_W     = 16,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sck,
  input  logic                sdi,
  input  logic                conv_done,
  input  logic [RES_BITS:0]   conv_value,
  output logic                sdo,
  output logic                sdo_oe,
  output logic [CFG_W-1:0]    cfg_word,
  output logic                conv_start
);
  localparam int FRAME_BITS = 3 + RES_BITS + TAIL_BITS;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CFG_N = CNT_W'(CFG_W);

  typedef enum logic [1:0] {ST_CONV, ST_SLEEP, ST_OUT} st_t;

  st_t                   state;
  logic                  cs_r, sck_r, sck_p, sdi_r;
  logic [CNT_W-1:0]      bitcnt;
  logic [FRAME_BITS-1:0] frame_sr;
  logic [CFG_W-1:0]      cfg_sr;

  function automatic logic [FRAME_BITS-1:0] frame_of(input logic [RES_BITS:0] v);
    return {2'b00, ~v[RES_BITS], v[RES_BITS-1:0], {TAIL_BITS{1'b0}}};
  endfunction

  wire sck_rise  = sck_r & ~sck_p;
  wire sck_fall  = ~sck_r & sck_p;
  wire in_frame  = (state == ST_OUT) && !cs_r;
  wire frame_end = in_frame && sck_rise && (bitcnt == LAST);
  wire abort     = (state == ST_OUT) && cs_r && (bitcnt != '0);

  assign sdo_oe = ~cs_r;
  assign sdo = (state == ST_CONV)  ? 1'b1 :
               (state == ST_SLEEP) ? 1'b0 : frame_sr[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_CONV;
      cs_r       <= 1'b1;
      sck_r      <= 1'b0;
      sck_p      <= 1'b0;
      sdi_r      <= 1'b0;
      bitcnt     <= '0;
      frame_sr   <= '0;
      cfg_sr     <= '0;
      cfg_word   <= CFG_RST;
      conv_start <= 1'b0;
    end else begin
      cs_r       <= cs_n;
      sck_r      <= sck;
      sck_p      <= sck_r;
      sdi_r      <= sdi;
      conv_start <= frame_end | abort;
      if (frame_end) cfg_word <= cfg_sr;
      case (state)
        ST_CONV: begin
          bitcnt <= '0;
          if (conv_done) begin
            frame_sr <= frame_of(conv_value);
            state    <= ST_SLEEP;
          end
        end
        ST_SLEEP: begin
          bitcnt <= '0;
          if (!cs_r) state <= ST_OUT;
        end
        default: begin
          if (frame_end || abort) begin
            state  <= ST_CONV;
            bitcnt <= '0;
          end else if (cs_r) begin
            state <= ST_SLEEP;
          end else begin
            if (sck_rise) begin
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt < CFG_N) cfg_sr <= {cfg_sr[CFG_W-2:0], sdi_r};
            end
            if (sck_fall && bitcnt != '0)
              frame_sr <= {frame_sr[FRAME_BITS-2:0], 1'b0};
          end
        end
      endcase
    end
  end

  p_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && conv_done) |=> (state == ST_SLEEP));

  p_bit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !sck_fall) |=> (state != ST_OUT || $stable(sdo)));

  p_frame_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (state == ST_CONV && conv_start && bitcnt == '0));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (state == ST_CONV && conv_start));

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_OUT) |=> $stable(cfg_word));

  p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= LAST);
endmodule

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sck = 0, sdi = 0, conv_done = 0;
  logic [17:0] conv_value = '0;
  logic sdo, sdo_oe, conv_start;
  logic [15:0] cfg_word;
  int tests = 0, fails = 0, starts = 0;
  bit finished = 0;
  logic [15:0] cfg_exp = '0;

  always #2 clk = ~clk;

  adc_serial_port i_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .conv_done(conv_done), .conv_value(conv_value), .sdo(sdo),
    .sdo_oe(sdo_oe), .cfg_word(cfg_word), .conv_start(conv_start));

  always @(posedge clk) if (rst_n && conv_start) starts++;

  function automatic logic [23:0] exp_frame(input logic [17:0] v);
    logic sgn;
    sgn = ($signed(v) >= 0) ? 1'b1 : 1'b0;
    return {2'b00, sgn, v[16:0], 4'b0000};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic pulse_done(input logic [17:0] v);
    conv_value = v; conv_done = 1; tick(1);
    conv_done = 0; tick(4);
  endtask

  task automatic read_bits(input int n, input logic [17:0] v, input logic [15:0] cfg);
    logic [23:0] f;
    f = exp_frame(v);
    for (int i = 0; i < n; i++) begin
      check((i == 2) ? "R5 sign" : "R4 frame bit", {31'b0, sdo}, {31'b0, f[23-i]});
      sdi = (i < 16) ? cfg[15-i] : 1'($urandom);
      sck = 1; tick(4);
      if (i != 23) check("R6 hold after rise", {31'b0, sdo}, {31'b0, f[23-i]});
      sck = 0; tick(4);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    tick(3); rst_n = 1; tick(2);
    check("R11 cfg reset", {16'b0, cfg_word}, 0);
    check("R11 no start", {31'b0, conv_start}, 0);
    check("R1 oe off", {31'b0, sdo_oe}, 0);
    cs_n = 0; tick(4);
    check("R1 oe on", {31'b0, sdo_oe}, 1);
    check("R2 busy", {31'b0, sdo}, 1);
    pulse_done(18'h00000);
    check("R3 ready cs low", {31'b0, sdo}, 0);
    pulse_done(18'h2AAAA);
    begin
      int s0 = starts;
      logic [15:0] c = 16'hA55A;
      read_bits(24, 18'h00000, c);
      tick(2);
      check("R3 later done ignored / R7 start", starts, s0 + 1);
      check("R10 cfg", {16'b0, cfg_word}, {16'b0, c});
      cfg_exp = c;
      check("R2 busy after frame", {31'b0, sdo}, 1);
    end
    for (int it = 0; it < 44; it++) begin
      logic [17:0] v;
      logic [15:0] c;
      int mode, s0;
      case (it)
        0: v = 18'h3FFFF;
        1: v = 18'h20000;
        2: v = 18'h1FFFF;
        default: v = 18'($urandom);
      endcase
      c = 16'($urandom);
      mode = (it < 3) ? 0 : int'($urandom % 4);
      cs_n = 1; tick(4);
      pulse_done(v);
      check("R1 hiz", {31'b0, sdo_oe}, 0);
      cs_n = 0; tick(4);
      check("R3 ready", {31'b0, sdo}, 0);
      s0 = starts;
      if (mode == 2) begin
        int k = 1 + int'($urandom % 23);
        read_bits(k, v, c);
        cs_n = 1; tick(4);
        check("R8 abort start", starts, s0 + 1);
        check("R8 cfg kept", {16'b0, cfg_word}, {16'b0, cfg_exp});
        cs_n = 0; tick(4);
        check("R2 busy after abort", {31'b0, sdo}, 1);
      end else begin
        if (mode == 3) begin
          cs_n = 1; tick(4);
          check("R9 no start", starts, s0);
          cs_n = 0; tick(4);
          check("R9 still ready", {31'b0, sdo}, 0);
        end
        read_bits(24, v, c);
        tick(2);
        check("R7 start", starts, s0 + 1);
        check("R10 cfg", {16'b0, cfg_word}, {16'b0, c});
        cfg_exp = c;
        check("R7 converting", {31'b0, sdo}, 1);
      end
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule